// File: doc/BRIEF.md
# Multiprocessor UART Receiver with Address Filter

This block receives asynchronous serial frames on a single line and hands completed bytes to a processor through a data register and a receive-complete flag. It works from a 16x oversampling tick supplied by a baud generator outside the block. Each frame carries 8 data bits, optionally a ninth data bit, and one stop bit. Every bit is decided by a vote of three samples taken near its centre.

A low stop bit latches a framing-error flag. Only software can clear that flag. In multiprocessor networks, address recognition can be switched on. The processor is then flagged only for frames that carry the address marker and whose byte matches this node's masked address or its broadcast address. All other traffic is absorbed without disturbing the processor.

A frame that completes while the previous byte is still unread is dropped, so the unread byte is never overwritten.

Top module: `mp_uart_rx`

## Requirements
- R1: With the line idle high, a low level seen on a tick begins a frame. If the vote at the middle of the start bit is high, the frame is abandoned with no change to any output, and a later valid frame is then received normally.
- R2: Each bit is the majority of three samples taken on ticks 7, 8 and 9 after the start of its 16-tick bit period. A disturbance lasting one tick at the bit centre does not change the received value.
- R3: The data bits arrive least significant bit first: 8 data bits, then a ninth data bit when `nine_bit_i` is 1, then the stop bit.
- R4: A stop bit voted low sets `frame_err_o`. The flag stays set through later frames with valid stop bits and is cleared only by a `fe_clr_i` pulse.
- R5: With `addr_en_i` = 0, every completed frame that finds `rx_done_o` low loads the byte into `rx_data_o`, sets `rx_done_o`, and loads `rx_bit9_o`. `rx_bit9_o` takes the ninth data bit in 9-bit mode and the stop bit value in 8-bit mode.
- R6: With `addr_en_i` = 1, a frame is accepted only if its flag bit is 1; otherwise `rx_done_o` and `rx_data_o` are left unchanged. The flag bit is the ninth data bit in 9-bit mode and the stop bit in 8-bit mode.
- R7: With `addr_en_i` = 1, a frame whose byte satisfies `(byte & mask) == (addr & mask)` is accepted.
- R8: With `addr_en_i` = 1, a frame whose byte satisfies `(byte & (addr | mask)) == (addr | mask)` is accepted as a broadcast. A byte that matches neither R7 nor this rule is discarded.
- R9: A frame that completes while `rx_done_o` is 1 is discarded, and `rx_data_o` keeps the earlier byte.
- R10: A `rx_clr_i` pulse clears `rx_done_o` on the following clock edge.
- R11: After reset, `rx_data_o`, `rx_bit9_o`, `rx_done_o` and `frame_err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Oversampling strobe, 16 per bit period |
| rxd_i | input | 1 | Serial line, idle high |
| nine_bit_i | input | 1 | 1: frame carries a ninth data bit |
| addr_en_i | input | 1 | 1: address recognition on |
| slave_addr_i | input | 8 | Node address |
| slave_mask_i | input | 8 | Address mask, 1 marks a compared bit |
| rx_clr_i | input | 1 | Clears the receive-complete flag |
| fe_clr_i | input | 1 | Clears the framing-error flag |
| rx_data_o | output | 8 | Last accepted byte |
| rx_bit9_o | output | 1 | Ninth bit, or stop bit in 8-bit mode, of the last accepted frame |
| rx_done_o | output | 1 | Receive-complete flag |
| frame_err_o | output | 1 | Sticky framing-error flag |

## Verification
The hardest situations to reach from the ports involve exact timing on the serial line. One is a line disturbance that hits exactly one of the three votes of a bit. Another is a start bit that drops and recovers before its middle. The stimulus drives the line in whole tick periods from a free-running tick, so a one-tick pulse placed eight ticks into a data bit always lands on the centre vote alone. A low pulse of three ticks creates a false start. The address filter is hard to hit with random bytes. The random frames are therefore built to match the given address, to match the broadcast address, to differ from the address in one compared bit, or to be fully random.

// File: rtl/mprx_pkg.sv
package mprx_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction
endpackage

// File: rtl/mprx_sync.sv
module mprx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '1;
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/mprx_sampler.sv
module mprx_sampler #(
  parameter int OSR = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic restart_i,
  input  logic line_i,
  output logic vote_vld_o,
  output logic vote_o,
  output logic bit_end_o
);
  import mprx_pkg::*;

  localparam int PW = $clog2(OSR);
  // k-th tick after a bit boundary sees phase k-1: votes on ticks OSR/2-1 .. OSR/2+1
  localparam int S0 = OSR / 2 - 2;
  localparam int S1 = OSR / 2 - 1;
  localparam int S2 = OSR / 2;

  logic [PW-1:0] phase_q;
  logic [1:0]    smp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      smp_q   <= '0;
    end else if (restart_i) begin
      phase_q <= '0;
    end else if (run_i && tick_i) begin
      phase_q <= (phase_q == PW'(OSR - 1)) ? '0 : phase_q + 1'b1;
      if (phase_q == PW'(S0) || phase_q == PW'(S1)) smp_q <= {smp_q[0], line_i};
    end
  end

  assign vote_vld_o = run_i && tick_i && (phase_q == PW'(S2));
  assign vote_o     = maj3({smp_q, line_i});
  assign bit_end_o  = run_i && tick_i && (phase_q == PW'(OSR - 1));
endmodule

// File: rtl/mprx_frame_ctrl.sv
module mprx_frame_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          line_i,
  input  logic          nine_bit_i,
  input  logic          vote_vld_i,
  input  logic          vote_i,
  input  logic          bit_end_i,
  output logic          run_o,
  output logic          restart_o,
  output logic          frame_end_o,
  output logic          stop_o,
  output logic [DW-1:0] byte_o,
  output logic          bit9_o
);
  import mprx_pkg::*;

  localparam int IW = $clog2(DW + 1);

  rx_state_e     state_q;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] last_idx;
  logic [DW-1:0] shreg_q;
  logic          bit9_q;

  assign last_idx  = nine_bit_i ? IW'(DW) : IW'(DW - 1);
  assign restart_o = (state_q == RX_IDLE) && tick_i && !line_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      idx_q   <= '0;
      shreg_q <= '0;
      bit9_q  <= 1'b0;
    end else begin
      unique case (state_q)
        RX_IDLE: if (restart_o) state_q <= RX_START;
        RX_START: begin
          if (vote_vld_i && vote_i) state_q <= RX_IDLE;  // false start
          else if (bit_end_i) begin
            state_q <= RX_DATA;
            idx_q   <= '0;
          end
        end
        RX_DATA: begin
          if (vote_vld_i) begin
            if (idx_q < IW'(DW)) shreg_q <= {vote_i, shreg_q[DW-1:1]};
            else                 bit9_q  <= vote_i;
          end
          if (bit_end_i) begin
            if (idx_q == last_idx) state_q <= RX_STOP;
            else                   idx_q   <= idx_q + 1'b1;
          end
        end
        RX_STOP: if (vote_vld_i) state_q <= RX_IDLE;
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign run_o       = (state_q != RX_IDLE);
  assign frame_end_o = (state_q == RX_STOP) && vote_vld_i;
  assign stop_o      = vote_i;
  assign byte_o      = shreg_q;
  assign bit9_o      = bit9_q;
endmodule

// File: rtl/mprx_addr_filter.sv
module mprx_addr_filter #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] byte_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] mask_i,
  output logic          hit_o
);
  logic [DW-1:0] given;
  logic [DW-1:0] bcast;

  assign given = addr_i & mask_i;
  assign bcast = addr_i | mask_i;
  assign hit_o = ((byte_i & mask_i) == given) || ((byte_i & bcast) == bcast);
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              nine_bit_i,
  input  logic              addr_en_i,
  input  logic [DATA_W-1:0] slave_addr_i,
  input  logic [DATA_W-1:0] slave_mask_i,
  input  logic              rx_clr_i,
  input  logic              fe_clr_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_bit9_o,
  output logic              rx_done_o,
  output logic              frame_err_o
);
  logic              line;
  logic              run, restart, vote_vld, vote, bit_end;
  logic              frame_end, stop_bit, ninth, flag_bit, hit, accept;
  logic [DATA_W-1:0] rx_byte;
  logic [DATA_W-1:0] data_q;
  logic              bit9_q, done_q, fe_q;

  mprx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(line)
  );

  mprx_sampler #(.OSR(OSR)) u_sampler (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .run_i(run),
    .restart_i(restart), .line_i(line), .vote_vld_o(vote_vld),
    .vote_o(vote), .bit_end_o(bit_end)
  );

  mprx_frame_ctrl #(.DW(DATA_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .line_i(line),
    .nine_bit_i(nine_bit_i), .vote_vld_i(vote_vld), .vote_i(vote),
    .bit_end_i(bit_end), .run_o(run), .restart_o(restart),
    .frame_end_o(frame_end), .stop_o(stop_bit), .byte_o(rx_byte), .bit9_o(ninth)
  );

  mprx_addr_filter #(.DW(DATA_W)) u_filter (
    .byte_i(rx_byte), .addr_i(slave_addr_i), .mask_i(slave_mask_i), .hit_o(hit)
  );

  // in 8-bit mode the stop bit stands in for the address marker
  assign flag_bit = nine_bit_i ? ninth : stop_bit;
  assign accept   = frame_end && !done_q && (!addr_en_i || (flag_bit && hit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      bit9_q <= 1'b0;
      done_q <= 1'b0;
      fe_q   <= 1'b0;
    end else begin
      if (accept) begin
        data_q <= rx_byte;
        bit9_q <= flag_bit;
      end
      if (rx_clr_i)    done_q <= 1'b0;
      else if (accept) done_q <= 1'b1;
      if (frame_end && !stop_bit) fe_q <= 1'b1;
      else if (fe_clr_i)          fe_q <= 1'b0;
    end
  end

  assign rx_data_o   = data_q;
  assign rx_bit9_o   = bit9_q;
  assign rx_done_o   = done_q;
  assign frame_err_o = fe_q;
endmodule

// File: rtl/mprx_checker.sv
module mprx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_clr_i,
  input logic              fe_clr_i,
  input logic              addr_en_i,
  input logic              frame_end,
  input logic              stop_bit,
  input logic              flag_bit,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_done_o,
  input logic              frame_err_o
);
  AST_STOP_LOW_SETS_FE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end && !stop_bit |=> frame_err_o); // R4
  AST_FE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o && !fe_clr_i |=> frame_err_o); // R4
  AST_FE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fe_clr_i && !(frame_end && !stop_bit) |=> !frame_err_o); // R4
  AST_FLAG_FILTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end && addr_en_i && !flag_bit && !rx_done_o |=> !rx_done_o); // R6
  AST_NO_OVERWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o && !rx_clr_i |=> rx_done_o && $stable(rx_data_o)); // R9
  AST_DONE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_clr_i |=> !rx_done_o); // R10
  AST_DONE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_done_o && !frame_end |=> !rx_done_o); // R5
  AST_DATA_ONLY_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end |=> $stable(rx_data_o)); // R5
endmodule

bind mp_uart_rx mprx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_clr_i(rx_clr_i), .fe_clr_i(fe_clr_i),
  .addr_en_i(addr_en_i), .frame_end(frame_end), .stop_bit(stop_bit),
  .flag_bit(flag_bit), .rx_data_o(rx_data_o), .rx_done_o(rx_done_o),
  .frame_err_o(frame_err_o)
);

// File: tb/tb_mp_uart_rx.sv
module tb_mp_uart_rx;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 4;
  localparam int BITC       = 16 * TDIV;

  logic       clk, rst_ni, tick_i, rxd_i, nine_bit_i, addr_en_i, rx_clr_i, fe_clr_i;
  logic [7:0] slave_addr_i, slave_mask_i, rx_data_o;
  logic       rx_bit9_o, rx_done_o, frame_err_o;

  int   n_chk = 0, n_err = 0, tcnt = 0;
  bit   finished = 0;
  logic [7:0] m_data;
  logic       m_b9, m_done, m_fe;

  mp_uart_rx dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .rxd_i(rxd_i),
    .nine_bit_i(nine_bit_i), .addr_en_i(addr_en_i), .slave_addr_i(slave_addr_i),
    .slave_mask_i(slave_mask_i), .rx_clr_i(rx_clr_i), .fe_clr_i(fe_clr_i),
    .rx_data_o(rx_data_o), .rx_bit9_o(rx_bit9_o), .rx_done_o(rx_done_o),
    .frame_err_o(frame_err_o)
  );

  initial begin
    clk = 0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  initial begin
    tick_i = 0;
    forever begin
      @(negedge clk);
      tcnt   = (tcnt + 1) % TDIV;
      tick_i = (tcnt == 0);
    end
  end

  function automatic logic addr_hit(logic [7:0] d, logic [7:0] a, logic [7:0] m);
    return ((d & m) == (a & m)) || ((d & (a | m)) == (a | m));  // R7 R8
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " done"},  32'(rx_done_o),   32'(m_done));
    chk({tag, " data"},  32'(rx_data_o),   32'(m_data));
    chk({tag, " bit9"},  32'(rx_bit9_o),   32'(m_b9));
    chk({tag, " ferr"},  32'(frame_err_o), 32'(m_fe));
  endtask

  task automatic clr_rx();
    rx_clr_i = 1; @(negedge clk); rx_clr_i = 0; @(negedge clk);
    m_done = 0;
  endtask

  task automatic clr_fe();
    fe_clr_i = 1; @(negedge clk); fe_clr_i = 0; @(negedge clk);
    m_fe = 0;
  endtask

  task automatic send_bit(logic v, bit glitch);
    rxd_i = v;
    if (glitch) begin
      repeat (8 * TDIV) @(negedge clk);
      rxd_i = ~v;
      repeat (TDIV) @(negedge clk);
      rxd_i = v;
      repeat (7 * TDIV) @(negedge clk);
    end else begin
      repeat (BITC) @(negedge clk);
    end
  endtask

  task automatic frame(logic [7:0] d, logic b9, logic stp, int gl = -1);
    logic fl;
    send_bit(1'b0, 0);
    for (int i = 0; i < 8; i++) send_bit(d[i], gl == i);
    if (nine_bit_i) send_bit(b9, 0);
    send_bit(stp, 0);
    rxd_i = 1'b1;
    repeat (BITC) @(negedge clk);
    fl = nine_bit_i ? b9 : stp;
    if (!stp) m_fe = 1;
    if (!m_done && (!addr_en_i || (fl && addr_hit(d, slave_addr_i, slave_mask_i)))) begin
      m_data = d; m_b9 = fl; m_done = 1;
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_ni = 0; rxd_i = 1; nine_bit_i = 0; addr_en_i = 0;
    rx_clr_i = 0; fe_clr_i = 0; slave_addr_i = 0; slave_mask_i = 0;
    m_data = 0; m_b9 = 0; m_done = 0; m_fe = 0;
    repeat (5) @(negedge clk);
    rst_ni = 1;
    repeat (3) @(negedge clk);
    check_all("R11 reset");

    frame(8'hA5, 1'b0, 1'b1);
    check_all("R5 R3 8-bit frame");
    chk("R3 lsb-first byte", 32'(rx_data_o), 32'hA5);
    clr_rx();
    chk("R10 clear", 32'(rx_done_o), 0);

    nine_bit_i = 1;
    frame(8'h3C, 1'b0, 1'b1);
    check_all("R3 9-bit frame");
    clr_rx();

    frame(8'h0F, 1'b1, 1'b1, 2);
    check_all("R2 centre glitch");
    chk("R2 glitch byte", 32'(rx_data_o), 32'h0F);
    clr_rx();

    nine_bit_i = 0;
    rxd_i = 0; repeat (3 * TDIV) @(negedge clk);
    rxd_i = 1; repeat (2 * BITC) @(negedge clk);
    chk("R1 false start no flag", 32'(rx_done_o), 0);
    frame(8'h81, 1'b0, 1'b1);
    check_all("R1 frame after false start");
    clr_rx();

    frame(8'h55, 1'b0, 1'b0);
    check_all("R4 missing stop");
    clr_rx();
    frame(8'h66, 1'b0, 1'b1);
    check_all("R4 sticky after good stop");
    chk("R4 still set", 32'(frame_err_o), 1);
    clr_fe();
    chk("R4 cleared by write", 32'(frame_err_o), 0);

    frame(8'h99, 1'b0, 1'b1);
    check_all("R9 overrun dropped");
    chk("R9 old byte kept", 32'(rx_data_o), 32'h66);
    clr_rx();

    addr_en_i = 1; nine_bit_i = 1;
    slave_addr_i = 8'h35; slave_mask_i = 8'hF3;
    frame(8'h39, 1'b1, 1'b1);
    check_all("R7 given address");
    clr_rx();
    frame(8'h35, 1'b0, 1'b1);
    check_all("R6 data frame ignored");
    frame(8'h00, 1'b1, 1'b1);
    check_all("R7 R8 mismatch ignored");
    frame(8'hFF, 1'b1, 1'b1);
    check_all("R8 broadcast");
    clr_rx();
    nine_bit_i = 0;
    frame(8'h35, 1'b0, 1'b0);
    check_all("R6 8-bit low stop ignored");
    clr_fe();
    frame(8'h31, 1'b0, 1'b1);
    check_all("R6 R7 8-bit addressed");
    clr_rx();

    for (int n = 0; n < 48; n++) begin
      logic [7:0] d, r;
      int sel;
      nine_bit_i   = 1'($urandom % 2);
      addr_en_i    = 1'($urandom % 2);
      slave_addr_i = 8'($urandom);
      slave_mask_i = 8'($urandom);
      r   = 8'($urandom);
      sel = $urandom % 4;
      case (sel)
        0: d = (slave_addr_i & slave_mask_i) | (r & ~slave_mask_i);
        1: d = slave_addr_i | slave_mask_i | r;
        2: d = r;
        default: d = slave_addr_i ^ (slave_mask_i & (8'h01 << (r % 8)));
      endcase
      if ($urandom % 5 != 0) clr_rx();
      if ($urandom % 4 == 0) clr_fe();
      frame(d, 1'($urandom % 4 != 0), 1'($urandom % 6 != 0));
      check_all("R5 R6 R7 R8 R9 random");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R5: actual hung expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule